// File: doc/BRIEF.md
# Serial Flash Status Register Unit

This block is the status and command-gating slice of a serial flash slave. It watches a mode 0 SPI bus (chip select, serial clock, serial data in), oversampled on the system clock, and decodes the first byte of each transaction as an opcode. It keeps two status bytes. They hold a busy flag, a write-enable latch, program-suspend and erase-suspend flags, a reset-enable bit and a lockdown-enable bit. A status-read transaction streams these bytes back on the serial output.

The sticky enable bits decide whether the Reset, Sector Lockdown and Freeze Lockdown commands take effect or are silently dropped. A freeze clears the lockdown-enable bit until the next power-up reset. A programmable cycle timer stands in for program and erase operations. This gives the busy flag, suspend and resume, and the polling path something real to report.

Top module: `ssr_status_unit`

## Requirements
- R1: `so_oe` is 0 whenever chip select is high and throughout the eight opcode bits; during a status read `so` changes after falling SCK edges and each bit is valid before the next rising edge.
- R2: Opcode 0x05 (MSB first) starts a status read: byte 1 is sent MSB first, then byte 2, then byte 1 again, alternating until chip select rises.
- R3: Byte 1 layout is bit0 busy, bit1 write-enable, bits 7..2 zero. Byte 2 layout is bit0 busy, bit1 erase-suspend, bit2 program-suspend, bit3 lockdown-enable, bit4 reset-enable, bits 7..5 zero. Busy is sampled afresh for every byte sent.
- R4: Opcode 0x06 sets the write-enable latch and 0x04 clears it. The latch also clears after an accepted status write, lockdown, freeze, Reset, or the end of a program or erase.
- R5: Opcode 0x31 followed by one data byte copies data bit4 to reset-enable and data bit3 to lockdown-enable. It acts only when write-enable is 1 and the unit is not busy.
- R6: Reset (0xF0) is ignored while reset-enable is 0. When reset-enable is 1, Reset clears write-enable, busy and both suspend flags, and leaves reset-enable and lockdown-enable unchanged.
- R7: Sector Lockdown (0x33) and Freeze Lockdown (0x34) are ignored unless lockdown-enable and write-enable are both 1 and the unit is not busy.
- R8: An accepted Freeze clears lockdown-enable. Later status writes cannot set it again until the next power-up reset.
- R9: Program (0x02) or erase (0x20), with write-enable 1 and no operation pending, holds busy at 1 for BUSY_CYCLES clocks and then releases it.
- R10: While busy, every opcode other than 0x05, 0xB0 and 0xF0 is ignored.
- R11: Suspend (0xB0) while busy clears busy, sets program-suspend or erase-suspend by operation type, and freezes the timer. Resume (0xD0) clears the flag and busy returns. A new program or erase is ignored while suspended.
- R12: After power-up reset both status bytes read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| si | input | 1 | SPI serial data in |
| so | output | 1 | SPI serial data out |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |

## Verification
A table of twenty command-then-read pairs walks the enable bits through set, clear, gated and frozen states. Each read shows at once whether a command took effect or was dropped. Long streaming reads check the strict byte alternation. They also poll the busy bit until it falls, which separates a live busy flag from one latched at the start of the read. Program and erase runs are suspended, resumed and aborted by Reset so that the two suspend flags and the abort path can be told apart. A second power-up reset shows that the freeze lasts only until power is cycled.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  localparam int BYTE_W   = 8;
  localparam int RSTE_BIT = 4;
  localparam int SLE_BIT  = 3;

  localparam logic [BYTE_W-1:0] OP_RDSR   = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WREN   = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRDI   = 8'h04;
  localparam logic [BYTE_W-1:0] OP_WRHI   = 8'h31;
  localparam logic [BYTE_W-1:0] OP_PROG   = 8'h02;
  localparam logic [BYTE_W-1:0] OP_ERASE  = 8'h20;
  localparam logic [BYTE_W-1:0] OP_LOCK   = 8'h33;
  localparam logic [BYTE_W-1:0] OP_FREEZE = 8'h34;
  localparam logic [BYTE_W-1:0] OP_SUSP   = 8'hB0;
  localparam logic [BYTE_W-1:0] OP_RESUME = 8'hD0;
  localparam logic [BYTE_W-1:0] OP_RESET  = 8'hF0;

  typedef struct packed {
    logic busy;
    logic wel;
    logic ps;
    logic es;
    logic sle;
    logic rste;
  } stat_t;

  function automatic logic [BYTE_W-1:0] pack_lo(stat_t s);
    return {{(BYTE_W-2){1'b0}}, s.wel, s.busy};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_hi(stat_t s);
    return {{(BYTE_W-5){1'b0}}, s.rste, s.sle, s.ps, s.es, s.busy};
  endfunction

endpackage

// File: rtl/ssr_spi_port.sv
module ssr_spi_port
  import ssr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic [BYTE_W-1:0] tx_lo,
  input  logic [BYTE_W-1:0] tx_hi,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_op,
  output logic              arg_valid,
  output logic [BYTE_W-1:0] arg_data,
  output logic              so,
  output logic              so_oe
);
  localparam int CNT_W = $clog2(2*BYTE_W+1);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] C_OP  = CNT_W'(BYTE_W-1);
  localparam logic [CNT_W-1:0] C_ARG = CNT_W'(2*BYTE_W-1);
  localparam logic [CNT_W-1:0] C_MAX = CNT_W'(2*BYTE_W);

  logic [2:0] sck_sh;
  logic [1:0] cs_sh, si_sh;
  logic       active, rise, fall;

  logic [BYTE_W-1:0] rx_q, rx_d, rx_next, op_q, op_d, arg_q, arg_d, tx_q, tx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  txb_q, txb_d;
  logic opv_q, opv_d, argv_q, argv_d, rd_q, rd_d, hi_q, hi_d, oe_q, oe_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sh <= '0;
      cs_sh  <= '1;
      si_sh  <= '0;
    end else begin
      sck_sh <= {sck_sh[1:0], sck};
      cs_sh  <= {cs_sh[0], cs_n};
      si_sh  <= {si_sh[0], si};
    end
  end

  assign active  = ~cs_sh[1];
  assign rise    = sck_sh[1] & ~sck_sh[2];
  assign fall    = ~sck_sh[1] & sck_sh[2];
  assign rx_next = {rx_q[BYTE_W-2:0], si_sh[1]};

  always_comb begin
    rx_d = rx_q;  cnt_d = cnt_q;  op_d = op_q;  arg_d = arg_q;
    tx_d = tx_q;  txb_d = txb_q;  rd_d = rd_q;  hi_d = hi_q;  oe_d = oe_q;
    opv_d = 1'b0;
    argv_d = 1'b0;
    if (!active) begin
      cnt_d = '0;  rd_d = 1'b0;  oe_d = 1'b0;  txb_d = '0;  hi_d = 1'b0;
    end else begin
      if (rise) begin
        rx_d = rx_next;
        if (cnt_q != C_MAX) cnt_d = cnt_q + 1'b1;
        if (cnt_q == C_OP) begin
          opv_d = 1'b1;
          op_d  = rx_next;
          rd_d  = (rx_next == OP_RDSR);
        end
        if (cnt_q == C_ARG) begin
          argv_d = 1'b1;
          arg_d  = rx_next;
        end
      end
      if (fall && rd_q) begin
        if (txb_q == '0) begin
          tx_d = hi_q ? tx_hi : tx_lo;
          hi_d = ~hi_q;
          oe_d = 1'b1;
        end else begin
          tx_d = tx_q << 1;
        end
        txb_d = txb_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;  cnt_q <= '0;  op_q <= '0;  arg_q <= '0;  tx_q <= '0;
      txb_q <= '0; opv_q <= 1'b0; argv_q <= 1'b0; rd_q <= 1'b0;
      hi_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      rx_q <= rx_d;  cnt_q <= cnt_d;  op_q <= op_d;  arg_q <= arg_d;  tx_q <= tx_d;
      txb_q <= txb_d; opv_q <= opv_d; argv_q <= argv_d; rd_q <= rd_d;
      hi_q <= hi_d; oe_q <= oe_d;
    end
  end

  assign cmd_valid = opv_q;
  assign cmd_op    = op_q;
  assign arg_valid = argv_q;
  assign arg_data  = arg_q;
  assign so        = tx_q[BYTE_W-1];
  assign so_oe     = oe_q;

endmodule

// File: rtl/ssr_busy_timer.sv
module ssr_busy_timer #(
  parameter int BUSY_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pause,
  input  logic abort,
  output logic running,
  output logic done
);
  localparam int CNT_W = $clog2(BUSY_CYCLES+1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES-1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d, done_q, done_d, cnt_en;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    cnt_en = 1'b0;
    if (abort) begin
      run_d = 1'b0;
    end else if (start) begin
      run_d  = 1'b1;
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (run_q && !pause) begin
      if (cnt_q == '0) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign running = run_q;
  assign done    = done_q;

endmodule

// File: rtl/ssr_status_ctl.sv
module ssr_status_ctl
  import ssr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_op,
  input  logic              arg_valid,
  input  logic [BYTE_W-1:0] arg_data,
  input  logic              op_running,
  input  logic              op_done,
  output logic              op_start,
  output logic              op_pause,
  output logic              op_abort,
  output logic              wr_fire,
  output logic              frozen,
  output stat_t             st
);
  logic wel_q, wel_d, ps_q, ps_d, es_q, es_d, sle_q, sle_d;
  logic rste_q, rste_d, frz_q, frz_d, kind_q, kind_d;
  logic busy, lock_ok, unused_arg;

  assign unused_arg = ^{arg_data[BYTE_W-1:RSTE_BIT+1], arg_data[SLE_BIT-1:0]};

  assign busy     = op_running & ~(ps_q | es_q);
  assign lock_ok  = wel_q & sle_q & ~busy;
  assign op_start = cmd_valid & ((cmd_op == OP_PROG) | (cmd_op == OP_ERASE))
                    & wel_q & ~op_running;
  assign op_abort = cmd_valid & (cmd_op == OP_RESET) & rste_q;
  assign op_pause = ps_q | es_q;
  assign wr_fire  = arg_valid & (cmd_op == OP_WRHI) & wel_q & ~busy;

  always_comb begin
    wel_d = wel_q; ps_d = ps_q; es_d = es_q; sle_d = sle_q;
    rste_d = rste_q; frz_d = frz_q; kind_d = kind_q;
    if (op_done) wel_d = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_WREN:   if (!busy) wel_d = 1'b1;
        OP_WRDI:   if (!busy) wel_d = 1'b0;
        OP_PROG,
        OP_ERASE:  if (op_start) kind_d = (cmd_op == OP_PROG);
        OP_LOCK:   if (lock_ok) wel_d = 1'b0;
        OP_FREEZE: if (lock_ok) begin
                     wel_d = 1'b0;
                     sle_d = 1'b0;
                     frz_d = 1'b1;
                   end
        OP_SUSP:   if (busy) begin
                     ps_d = kind_q;
                     es_d = ~kind_q;
                   end
        OP_RESUME: begin
                     ps_d = 1'b0;
                     es_d = 1'b0;
                   end
        OP_RESET:  if (rste_q) begin
                     wel_d = 1'b0;
                     ps_d  = 1'b0;
                     es_d  = 1'b0;
                   end
        default:   ;
      endcase
    end
    if (wr_fire) begin
      rste_d = arg_data[RSTE_BIT];
      sle_d  = arg_data[SLE_BIT] & ~frz_q;
      wel_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0; ps_q <= 1'b0; es_q <= 1'b0; sle_q <= 1'b0;
      rste_q <= 1'b0; frz_q <= 1'b0; kind_q <= 1'b0;
    end else begin
      wel_q <= wel_d; ps_q <= ps_d; es_q <= es_d; sle_q <= sle_d;
      rste_q <= rste_d; frz_q <= frz_d; kind_q <= kind_d;
    end
  end

  assign frozen  = frz_q;
  assign st.busy = busy;
  assign st.wel  = wel_q;
  assign st.ps   = ps_q;
  assign st.es   = es_q;
  assign st.sle  = sle_q;
  assign st.rste = rste_q;

endmodule

// File: rtl/ssr_status_unit.sv
module ssr_status_unit
  import ssr_pkg::*;
#(
  parameter int BUSY_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);
  stat_t             st;
  logic              cmd_valid, arg_valid, wr_fire, frozen;
  logic [BYTE_W-1:0] cmd_op, arg_data;
  logic              op_start, op_pause, op_abort, op_running, op_done;

  ssr_spi_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sck       (sck),
    .si        (si),
    .tx_lo     (pack_lo(st)),
    .tx_hi     (pack_hi(st)),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .arg_valid (arg_valid),
    .arg_data  (arg_data),
    .so        (so),
    .so_oe     (so_oe)
  );

  ssr_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (op_start),
    .pause   (op_pause),
    .abort   (op_abort),
    .running (op_running),
    .done    (op_done)
  );

  ssr_status_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .arg_valid  (arg_valid),
    .arg_data   (arg_data),
    .op_running (op_running),
    .op_done    (op_done),
    .op_start   (op_start),
    .op_pause   (op_pause),
    .op_abort   (op_abort),
    .wr_fire    (wr_fire),
    .frozen     (frozen),
    .st         (st)
  );

endmodule

// File: rtl/ssr_status_chk.sv
module ssr_status_chk
  import ssr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              so_oe,
  input logic              busy,
  input logic              wel,
  input logic              ps,
  input logic              es,
  input logic              sle,
  input logic              rste,
  input logic              frozen,
  input logic              wr_fire,
  input logic              cmd_valid,
  input logic [BYTE_W-1:0] cmd_op
);

  assert_oe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

  assert_rste_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rste) |-> $past(wr_fire));

  assert_sle_fall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sle) |-> ($past(wr_fire) || $past(cmd_valid && (cmd_op == OP_FREEZE))));

  assert_frozen_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !sle);

  assert_start_needs_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(ps || es)) |-> $past(wel));

  assert_suspend_from_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps || es) |-> $past(busy));

endmodule

bind ssr_status_unit ssr_status_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .so_oe     (so_oe),
  .busy      (st.busy),
  .wel       (st.wel),
  .ps        (st.ps),
  .es        (st.es),
  .sle       (st.sle),
  .rste      (st.rste),
  .frozen    (frozen),
  .wr_fire   (wr_fire),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op)
);

// File: tb/tb_ssr_status_unit.sv
module tb_ssr_status_unit;
  import ssr_pkg::*;

  localparam int BUSY = 1500;
  localparam int NVEC = 20;
  // {opcode, data, expected byte1, expected byte2}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h31_18_00_00, 32'h06_00_02_00, 32'h04_00_00_00, 32'h06_00_02_00,
    32'h31_18_00_18, 32'h06_00_02_18, 32'h33_00_00_18, 32'h06_00_02_18,
    32'hF0_00_00_18, 32'h06_00_02_18, 32'h31_00_00_00, 32'h06_00_02_00,
    32'hF0_00_02_00, 32'h33_00_02_00, 32'h34_00_02_00, 32'h31_08_00_08,
    32'h06_00_02_08, 32'h34_00_00_00, 32'h06_00_02_00, 32'h31_18_00_10
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  int   n_chk = 0, n_fail = 0;
  logic oe_seen = 1'b0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  ssr_status_unit #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic bit_x(input logic d, output logic q);
    si = d;
    repeat (4) @(negedge clk);
    q = so;
    if (so_oe) oe_seen = 1'b1;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      bit_x(d[i], b);
      q[i] = b;
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] op, input logic [7:0] dat, input logic two);
    logic [7:0] q;
    cs_low();
    byte_x(op, q);
    if (two) byte_x(dat, q);
    cs_high();
  endtask

  task automatic rd2(output logic [7:0] b1, output logic [7:0] b2, output logic op_oe);
    logic [7:0] q;
    cs_low();
    oe_seen = 1'b0;
    byte_x(OP_RDSR, q);
    op_oe = oe_seen;
    byte_x(8'h00, b1);
    byte_x(8'h00, b2);
    cs_high();
  endtask

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      OP_WREN, OP_WRDI: return "R4 write-enable";
      OP_WRHI:          return "R5 status write";
      OP_RESET:         return "R6 reset gating";
      OP_LOCK:          return "R7 lockdown gating";
      default:          return "R8 freeze";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] b1, b2, q;
    logic       ooe, cleared;
    int         polls;

    repeat (5) @(negedge clk);
    check("R1 so_oe in reset", {7'b0, so_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state, R1 output disabled during opcode
    rd2(b1, b2, ooe);
    check("R12 byte1 after reset", b1, 8'h00);
    check("R12 byte2 after reset", b2, 8'h00);
    check("R1 so_oe during opcode", {7'b0, ooe}, 8'h00);
    check("R1 so_oe with cs high", {7'b0, so_oe}, 8'h00);

    // Vector table: command, then status read (R3 layout throughout)
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] op, dat, e1, e2;
      {op, dat, e1, e2} = VEC[i];
      send(op, dat, op == OP_WRHI);
      rd2(b1, b2, ooe);
      check($sformatf("%s vec %0d byte1", tag_of(op), i), b1, e1);
      check($sformatf("%s vec %0d byte2", tag_of(op), i), b2, e2);
    end

    // R2 streaming alternation with distinct bytes (R3)
    send(OP_WREN, 8'h00, 1'b0);
    cs_low();
    byte_x(OP_RDSR, q);
    for (int k = 0; k < 5; k++) begin
      byte_x(8'h00, q);
      check($sformatf("R2 stream byte %0d", k), q, (k % 2 == 0) ? 8'h02 : 8'h10);
    end
    cs_high();
    check("R1 so_oe after read", {7'b0, so_oe}, 8'h00);

    // R9 program start, R10 write-disable ignored while busy
    send(OP_PROG, 8'h00, 1'b0);
    rd2(b1, b2, ooe);
    check("R9 busy byte1", b1, 8'h03);
    check("R3 busy in byte2", b2, 8'h11);
    send(OP_WRDI, 8'h00, 1'b0);
    rd2(b1, b2, ooe);
    check("R10 WRDI ignored while busy", b1, 8'h03);
    send(OP_WRHI, 8'h00, 1'b1);
    rd2(b1, b2, ooe);
    check("R10 status write ignored while busy", b2, 8'h11);

    // R11 program suspend, erase ignored while suspended, resume
    send(OP_SUSP, 8'h00, 1'b0);
    rd2(b1, b2, ooe);
    check("R11 suspend byte1", b1, 8'h02);
    check("R11 program-suspend byte2", b2, 8'h14);
    send(OP_ERASE, 8'h00, 1'b0);
    rd2(b1, b2, ooe);
    check("R11 erase ignored when suspended b1", b1, 8'h02);
    check("R11 erase ignored when suspended b2", b2, 8'h14);
    send(OP_RESUME, 8'h00, 1'b0);
    rd2(b1, b2, ooe);
    check("R11 resume byte1", b1, 8'h03);
    check("R11 resume byte2", b2, 8'h11);

    // R6 enabled Reset aborts the operation
    send(OP_RESET, 8'h00, 1'b0);
    rd2(b1, b2, ooe);
    check("R6 reset byte1", b1, 8'h00);
    check("R6 reset byte2 keeps enable", b2, 8'h10);

    // R11 erase suspend, then R9 completion by polling (R3 live busy)
    send(OP_WREN, 8'h00, 1'b0);
    send(OP_ERASE, 8'h00, 1'b0);
    send(OP_SUSP, 8'h00, 1'b0);
    rd2(b1, b2, ooe);
    check("R11 erase-suspend byte1", b1, 8'h02);
    check("R11 erase-suspend byte2", b2, 8'h12);
    send(OP_RESUME, 8'h00, 1'b0);
    cleared = 1'b0;
    polls = 0;
    cs_low();
    byte_x(OP_RDSR, q);
    for (int k = 0; k < 60 && !cleared; k++) begin
      byte_x(8'h00, q);
      polls++;
      if (k == 0) check("R2 poll first byte", q, 8'h03);
      if (k == 1) check("R2 poll second byte", q, 8'h11);
      if (!q[0]) cleared = 1'b1;
    end
    cs_high();
    check("R9 busy falls while polling", {7'b0, cleared}, 8'h01);
    check("R9 busy held many bytes", {7'b0, polls > 5}, 8'h01);
    rd2(b1, b2, ooe);
    check("R4 WEL cleared after erase", b1, 8'h00);
    check("R9 byte2 idle after erase", b2, 8'h10);

    // R8 freeze lasts only until power-up reset
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd2(b1, b2, ooe);
    check("R12 byte2 after second reset", b2, 8'h00);
    send(OP_WREN, 8'h00, 1'b0);
    send(OP_WRHI, 8'h08, 1'b1);
    rd2(b1, b2, ooe);
    check("R8 lockdown-enable settable after power-up", b2, 8'h08);

    finish_run();
  end

endmodule